// File: doc/BRIEF.md
# Cartridge Bank-Switching Memory Mapper

The mapper sits behind a small CPU address window and decides, for every access, which byte of an internal ROM or RAM the window shows. The window splits into a lower and an upper segment, each one bank wide. The lower segment shows one of seven selectable ROM slices. It can also show a RAM slice, whose first quarter of the window takes writes and whose second quarter returns reads of the same cells. In the upper segment, a short write page and a short read page give access to one of four small RAM banks. The rest of the upper segment always shows the last ROM slice. The CPU changes the mapping by touching hotspot addresses near the top of the window.

The RAM ports are split by address, and the CPU cannot tell a read strobe from a write strobe on the cartridge bus. As a result, a read access to a write page still stores whatever value is on the data bus. That same value comes back as the read data. The ROM is filled through a separate load port.

All sizes follow from `WIN_W`, the window address width:
- A bank is 2^(WIN_W-1) bytes.
- The ROM holds 8 banks.
- The RAM is one bank. Its first half is the large RAM block. Its second half holds four small banks, each one eighth of a bank.
- With `WIN_W = 12`, the window is 4K, the ROM 16K, the RAM 2K, the RAM block 1K and each small bank 256 bytes. The slice hotspots are then offsets 0xFE0 to 0xFE7 and the bank hotspots 0xFE8 to 0xFEB.
- The default `WIN_W = 9` scales the same map down.

Lower-segment states:
- `SEG_ROM`: the lower segment shows ROM slice 0 to 6. Reset enters this state.
- `SEG_RAM`: the lower segment shows the RAM slice.

Transitions are evaluated on every access:
- `SEL_ROM`: a slice hotspot 0 to 6 moves either state to `SEG_ROM`.
- `SEL_RAM`: slice hotspot 7 moves either state to `SEG_RAM`.
- `HOLD`: any other access keeps the current state.

Top module: `cart_mapper`

## Requirements
- R1: After reset, `cpu_dout` is 0, the lower segment shows ROM slice 0 (state `SEG_ROM`) and RAM bank 0 is selected. RAM contents after reset are undefined.
- R2: In `SEG_ROM` with slice s, a read access at an offset below one bank returns ROM byte s*bank + offset on `cpu_dout` after the next rising edge.
- R3: An access of either kind at offset 2^WIN_W-32+k, with k from 0 to 7, selects slice k from the next access on. Slice 7 enters `SEG_RAM`; slices 0 to 6 enter `SEG_ROM`. The selection persists until the next slice hotspot.
- R4: In `SEG_RAM`, a write at offset o, where o is below half a bank, stores into RAM cell o. A read at offset half-bank + o returns that cell.
- R5: In `SEG_RAM`, a read access to the lower write page stores `cpu_din` into the addressed cell and returns `cpu_din` as the read data.
- R6: An access at offset 2^WIN_W-24+n, with n from 0 to 3, selects small RAM bank n. Bank n occupies RAM cells half-bank + n*(bank/8) onward. In the upper segment, the first bank/8 offsets write the selected bank and the next bank/8 offsets read it.
- R7: A read access to the small-bank write page stores `cpu_din` into the selected bank and returns `cpu_din`.
- R8: The four small banks are disjoint. Data written through one bank is not visible through another.
- R9: Upper-segment offsets from bank + bank/4 to the window top always read ROM slice 7, whatever slice the lower segment shows.
- R10: Write accesses to ROM regions or to read pages change no storage. `cpu_dout` changes only on read accesses.
- R11: While `rom_ld_en` is high, `rom_ld_data` is stored at ROM byte `rom_ld_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | WIN_W | Offset within the cartridge window |
| cpu_din | input | 8 | Data bus value seen by the cartridge |
| cpu_dout | output | 8 | Registered read data |
| cpu_acc | input | 1 | Access strobe, one cycle per access |
| cpu_wr | input | 1 | High for a write access |
| rom_ld_en | input | 1 | ROM load enable |
| rom_ld_addr | input | WIN_W+2 | ROM load byte address |
| rom_ld_data | input | 8 | ROM load data |

## Verification
The bench sweeps every lower offset under each of the seven ROM slices. If a slice register were off by one or kept stale bits, whole pages would come back from the wrong slice. Fills through the RAM write pages are read back through the read pages, with all four small banks filled before any is read. A bank index dropped from the RAM address would make the banks overwrite each other. The bench also reads the write pages to catch a design that returns stale RAM instead of the bus value or forgets to store it. It writes into ROM areas and read pages, then reads back to show nothing changed. A last sweep covers the fixed upper ROM, including the hotspots themselves.

// File: rtl/cart_mapper_pkg.sv
package cart_mapper_pkg;

    typedef enum logic {
        SEG_ROM = 1'b0,
        SEG_RAM = 1'b1
    } seg_state_t;

    typedef enum logic [2:0] {
        RG_LO_ROM = 3'd0,
        RG_LO_WR  = 3'd1,
        RG_LO_RD  = 3'd2,
        RG_BK_WR  = 3'd3,
        RG_BK_RD  = 3'd4,
        RG_HI_ROM = 3'd5
    } region_t;

    localparam logic [2:0] RAM_SLICE   = 3'd7;
    localparam logic [2:0] FIXED_SLICE = 3'd7;

endpackage

// File: rtl/cm_decode.sv
module cm_decode
    import cart_mapper_pkg::*;
#(
    parameter int WIN_W = 9
) (
    input  logic [WIN_W-1:0] addr,
    input  logic             lo_is_ram,
    output region_t          region,
    output logic             hot_slice,
    output logic             hot_bank,
    output logic [2:0]       hot_idx
);
    localparam int BW   = WIN_W - 1;
    localparam int SBW  = WIN_W - 4;
    localparam int HOT  = (1 << WIN_W) - 32;
    localparam logic [WIN_W-1:0] HOT_S = WIN_W'(HOT);
    localparam logic [WIN_W-1:0] HOT_B = WIN_W'(HOT + 8);

    always_comb begin
        hot_slice = (addr[WIN_W-1:3] == HOT_S[WIN_W-1:3]);
        hot_bank  = (addr[WIN_W-1:2] == HOT_B[WIN_W-1:2]);
        hot_idx   = addr[2:0];
    end

    always_comb begin
        if (!addr[BW]) begin
            if (lo_is_ram)
                region = addr[BW-1] ? RG_LO_RD : RG_LO_WR;
            else
                region = RG_LO_ROM;
        end else begin
            if (addr[BW-1:SBW+1] == '0)
                region = addr[SBW] ? RG_BK_RD : RG_BK_WR;
            else
                region = RG_HI_ROM;
        end
    end
endmodule

// File: rtl/cm_bank_ctrl.sv
module cm_bank_ctrl
    import cart_mapper_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc,
    input  logic       hot_slice,
    input  logic       hot_bank,
    input  logic [2:0] hot_idx,
    output seg_state_t seg_state,
    output logic [2:0] lo_slice,
    output logic [1:0] bank_sel,
    output logic       lo_is_ram
);
    seg_state_t seg_q, seg_d;
    logic [2:0] slice_q, slice_d;
    logic [1:0] bank_q, bank_d;
    logic       take_slice;

    always_comb begin
        take_slice = acc && hot_slice;
        seg_d      = seg_q;
        slice_d    = slice_q;
        unique case (seg_q)
            SEG_ROM: begin
                if (take_slice) begin
                    slice_d = hot_idx;
                    seg_d   = (hot_idx == RAM_SLICE) ? SEG_RAM : SEG_ROM;
                end
            end
            SEG_RAM: begin
                if (take_slice) begin
                    slice_d = hot_idx;
                    seg_d   = (hot_idx == RAM_SLICE) ? SEG_RAM : SEG_ROM;
                end
            end
        endcase
        bank_d = (acc && hot_bank) ? hot_idx[1:0] : bank_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q   <= SEG_ROM;
            slice_q <= 3'd0;
            bank_q  <= 2'd0;
        end else begin
            seg_q   <= seg_d;
            slice_q <= slice_d;
            bank_q  <= bank_d;
        end
    end

    always_comb begin
        seg_state = seg_q;
        lo_slice  = slice_q;
        bank_sel  = bank_q;
        lo_is_ram = (seg_q == SEG_RAM);
    end
endmodule

// File: rtl/cm_store.sv
module cm_store
    import cart_mapper_pkg::*;
#(
    parameter int WIN_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              wr,
    input  logic [WIN_W-2:0]  off,
    input  logic [7:0]        din,
    input  region_t           region,
    input  logic [2:0]        lo_slice,
    input  logic [1:0]        bank_sel,
    input  logic              ld_en,
    input  logic [WIN_W+1:0]  ld_addr,
    input  logic [7:0]        ld_data,
    output logic [7:0]        dout
);
    localparam int BW      = WIN_W - 1;
    localparam int SBW     = WIN_W - 4;
    localparam int ROM_AW  = BW + 3;
    localparam int ROM_N   = 1 << ROM_AW;
    localparam int RAM_N   = 1 << BW;

    logic [7:0]        rom_mem [ROM_N];
    logic [7:0]        ram_mem [RAM_N];
    logic [ROM_AW-1:0] rom_idx;
    logic [BW-1:0]     ram_idx;
    logic              ram_store;

    always_comb begin
        if (region == RG_HI_ROM)
            rom_idx = {FIXED_SLICE, off};
        else
            rom_idx = {lo_slice, off};
        if (region == RG_LO_WR || region == RG_LO_RD)
            ram_idx = {1'b0, off[BW-2:0]};
        else
            ram_idx = {1'b1, bank_sel, off[SBW-1:0]};
        ram_store = acc && (region == RG_LO_WR || region == RG_BK_WR);
    end

    always_ff @(posedge clk) begin
        if (ld_en)
            rom_mem[ld_addr] <= ld_data;
        if (ram_store)
            ram_mem[ram_idx] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= 8'h00;
        end else if (acc && !wr) begin
            unique case (region)
                RG_LO_ROM, RG_HI_ROM: dout <= rom_mem[rom_idx];
                RG_LO_WR,  RG_BK_WR:  dout <= din;
                RG_LO_RD,  RG_BK_RD:  dout <= ram_mem[ram_idx];
                default:              dout <= dout;
            endcase
        end
    end
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
    import cart_mapper_pkg::*;
#(
    parameter int WIN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIN_W-1:0] cpu_addr,
    input  logic [7:0]       cpu_din,
    output logic [7:0]       cpu_dout,
    input  logic             cpu_acc,
    input  logic             cpu_wr,
    input  logic             rom_ld_en,
    input  logic [WIN_W+1:0] rom_ld_addr,
    input  logic [7:0]       rom_ld_data
);
    region_t    region;
    seg_state_t seg_state;
    logic       hot_slice, hot_bank, lo_is_ram;
    logic [2:0] hot_idx, lo_slice;
    logic [1:0] bank_sel;

    cm_decode #(.WIN_W(WIN_W)) dec_i (
        .addr      (cpu_addr),
        .lo_is_ram (lo_is_ram),
        .region    (region),
        .hot_slice (hot_slice),
        .hot_bank  (hot_bank),
        .hot_idx   (hot_idx)
    );

    cm_bank_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (cpu_acc),
        .hot_slice (hot_slice),
        .hot_bank  (hot_bank),
        .hot_idx   (hot_idx),
        .seg_state (seg_state),
        .lo_slice  (lo_slice),
        .bank_sel  (bank_sel),
        .lo_is_ram (lo_is_ram)
    );

    cm_store #(.WIN_W(WIN_W)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (cpu_acc),
        .wr       (cpu_wr),
        .off      (cpu_addr[WIN_W-2:0]),
        .din      (cpu_din),
        .region   (region),
        .lo_slice (lo_slice),
        .bank_sel (bank_sel),
        .ld_en    (rom_ld_en),
        .ld_addr  (rom_ld_addr),
        .ld_data  (rom_ld_data),
        .dout     (cpu_dout)
    );
endmodule

// File: rtl/cart_mapper_chk.sv
module cart_mapper_chk
    import cart_mapper_pkg::*;
#(
    parameter int WIN_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIN_W-1:0] cpu_addr,
    input logic [7:0]       cpu_din,
    input logic [7:0]       cpu_dout,
    input logic             cpu_acc,
    input logic             cpu_wr,
    input region_t          region,
    input seg_state_t       seg_state,
    input logic [2:0]       lo_slice,
    input logic [1:0]       bank_sel
);
    localparam int HOT = (1 << WIN_W) - 32;
    localparam logic [WIN_W-1:0] HS_LO = WIN_W'(HOT);
    localparam logic [WIN_W-1:0] HS_HI = WIN_W'(HOT + 7);
    localparam logic [WIN_W-1:0] HB_LO = WIN_W'(HOT + 8);
    localparam logic [WIN_W-1:0] HB_HI = WIN_W'(HOT + 11);

    logic at_slice_hot, at_bank_hot;
    always_comb begin
        at_slice_hot = cpu_acc && cpu_addr >= HS_LO && cpu_addr <= HS_HI;
        at_bank_hot  = cpu_acc && cpu_addr >= HB_LO && cpu_addr <= HB_HI;
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (lo_slice == 3'd0 && bank_sel == 2'd0 && seg_state == SEG_ROM && cpu_dout == 8'h00));

    p_slice_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
        at_slice_hot |=> (lo_slice == $past(cpu_addr[2:0])));

    p_slice_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !at_slice_hot |=> $stable(lo_slice));

    p_ram_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        at_slice_hot |=> ((seg_state == SEG_RAM) == ($past(cpu_addr[2:0]) == 3'd7)));

    p_bank_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        at_bank_hot |=> (bank_sel == $past(cpu_addr[1:0])));

    p_bank_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !at_bank_hot |=> $stable(bank_sel));

    p_lo_echo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_acc && !cpu_wr && region == RG_LO_WR) |=> (cpu_dout == $past(cpu_din)));

    p_bk_echo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_acc && !cpu_wr && region == RG_BK_WR) |=> (cpu_dout == $past(cpu_din)));

    p_dout_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_acc && !cpu_wr) |=> $stable(cpu_dout));
endmodule

bind cart_mapper cart_mapper_chk #(.WIN_W(WIN_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_din   (cpu_din),
    .cpu_dout  (cpu_dout),
    .cpu_acc   (cpu_acc),
    .cpu_wr    (cpu_wr),
    .region    (region),
    .seg_state (seg_state),
    .lo_slice  (lo_slice),
    .bank_sel  (bank_sel)
);

// File: tb/cart_mapper_tb.sv
module cart_mapper_tb_top;
    localparam int WIN_W = 9;
    localparam int WIN   = 1 << WIN_W;
    localparam int BK    = WIN / 2;
    localparam int HALF  = BK / 2;
    localparam int SB    = BK / 8;
    localparam int HOT   = WIN - 32;
    localparam int ROMN  = BK * 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIN_W-1:0] cpu_addr = '0;
    logic [7:0]       cpu_din = '0;
    logic [7:0]       cpu_dout;
    logic             cpu_acc = 1'b0;
    logic             cpu_wr = 1'b0;
    logic             rom_ld_en = 1'b0;
    logic [WIN_W+1:0] rom_ld_addr = '0;
    logic [7:0]       rom_ld_data = '0;

    int checks = 0;
    int errors = 0;

    logic [7:0] rom_m [ROMN];
    logic [7:0] ram_m [BK];
    int         m_slice, m_bank;
    logic [7:0] m_dout;

    always #10 clk = ~clk;

    cart_mapper #(.WIN_W(WIN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
        .cpu_dout(cpu_dout), .cpu_acc(cpu_acc), .cpu_wr(cpu_wr),
        .rom_ld_en(rom_ld_en), .rom_ld_addr(rom_ld_addr), .rom_ld_data(rom_ld_data)
    );

    function automatic logic [7:0] rom_pat(int i);
        return 8'((i * 37) + ((i >> 8) * 11) + 5);
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_slice = 0;
        m_bank  = 0;
        m_dout  = 8'h00;
    endtask

    task automatic load_rom(int a, logic [7:0] d);
        @(negedge clk);
        rom_ld_en = 1'b1; rom_ld_addr = (WIN_W+2)'(a); rom_ld_data = d;
        @(negedge clk);
        rom_ld_en = 1'b0;
        rom_m[a] = d;
    endtask

    // One access with the bench model giving the expected output.
    task automatic access(string req, int a, bit w, logic [7:0] d);
        logic [7:0] exp;
        int off;
        exp = m_dout;
        if (a < BK) begin
            if (m_slice == 7) begin
                if (a < HALF) begin
                    ram_m[a] = d;
                    if (!w) exp = d;
                end else if (!w) exp = ram_m[a - HALF];
            end else if (!w) exp = rom_m[m_slice * BK + a];
        end else begin
            off = a - BK;
            if (off < SB) begin
                ram_m[HALF + m_bank * SB + off] = d;
                if (!w) exp = d;
            end else if (off < 2 * SB) begin
                if (!w) exp = ram_m[HALF + m_bank * SB + off - SB];
            end else if (!w) exp = rom_m[7 * BK + off];
        end
        if (a >= HOT && a < HOT + 8)       m_slice = a - HOT;
        if (a >= HOT + 8 && a < HOT + 12)  m_bank  = a - HOT - 8;
        m_dout = exp;
        @(negedge clk);
        cpu_addr = WIN_W'(a); cpu_wr = w; cpu_din = d; cpu_acc = 1'b1;
        @(negedge clk);
        cpu_acc = 1'b0; cpu_wr = 1'b0;
        check(req, cpu_dout, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        check("R1 dout after reset", cpu_dout, 8'h00);

        // R11: fill ROM through the load port
        for (int i = 0; i < ROMN; i++) load_rom(i, rom_pat(i));

        // R1 / R2: slice 0 is shown after reset
        for (int o = 0; o < BK; o++) access("R1 R2 slice0", o, 1'b0, 8'h00);

        // R3 / R2: sweep slices 1..6
        for (int s = 1; s < 7; s++) begin
            access("R3 slice hotspot", HOT + s, 1'b0, 8'h00);
            for (int o = 0; o < BK; o++) access("R2 lower ROM", o, 1'b0, 8'h00);
        end

        // R4: RAM slice write then read
        access("R3 RAM hotspot", HOT + 7, 1'b0, 8'h00);
        for (int o = 0; o < HALF; o++) access("R4 lower write", o, 1'b1, 8'(o * 3 + 1));
        for (int o = 0; o < HALF; o++) access("R4 lower read", HALF + o, 1'b0, 8'h00);

        // R5: reading the write page stores the bus value
        access("R5 read write-page", 5, 1'b0, 8'hA5);
        access("R5 readback", HALF + 5, 1'b0, 8'h00);

        // R10: write to a read page is ignored
        access("R10 write read-page", HALF + 12, 1'b1, 8'h5A);
        access("R10 readback", HALF + 12, 1'b0, 8'h00);

        // R6 / R8: fill all four small banks then read all
        for (int b = 0; b < 4; b++) begin
            access("R6 bank hotspot", HOT + 8 + b, 1'b0, 8'h00);
            for (int o = 0; o < SB; o++) access("R6 bank write", BK + o, 1'b1, 8'(b * 40 + o + 7));
        end
        for (int b = 0; b < 4; b++) begin
            access("R6 bank hotspot", HOT + 8 + b, 1'b0, 8'h00);
            for (int o = 0; o < SB; o++) access("R8 bank read", BK + SB + o, 1'b0, 8'h00);
        end

        // R7: read of the small-bank write page
        access("R7 bank select", HOT + 10, 1'b0, 8'h00);
        access("R7 read write-page", BK + 3, 1'b0, 8'hC3);
        access("R7 readback", BK + SB + 3, 1'b0, 8'h00);
        access("R8 other bank", HOT + 9, 1'b0, 8'h00);
        access("R8 other bank read", BK + SB + 3, 1'b0, 8'h00);

        // R9: fixed upper ROM with lower segment in RAM and ROM modes
        for (int o = BK + 2 * SB; o < WIN; o++) access("R9 fixed ROM", o, 1'b0, 8'h00);
        access("R3 slice2", HOT + 2, 1'b0, 8'h00);
        for (int o = BK + 2 * SB; o < HOT; o++) access("R9 fixed ROM", o, 1'b0, 8'h00);

        // R10: writes to ROM areas change nothing, dout holds
        access("R3 slice3", HOT + 3, 1'b0, 8'h00);
        access("R10 write lower ROM", 10, 1'b1, 8'hEE);
        access("R10 reread lower ROM", 10, 1'b0, 8'h00);
        access("R10 write upper ROM", WIN - 1, 1'b1, 8'hEE);
        access("R10 reread upper ROM", WIN - 1, 1'b0, 8'h00);

        // R11: reload one byte while running
        load_rom(3 * BK + 10, 8'h3C);
        access("R11 reloaded byte", 10, 1'b0, 8'h00);

        // R1: reset returns to slice 0
        access("R3 slice5", HOT + 5, 1'b0, 8'h00);
        do_reset();
        check("R1 dout after second reset", cpu_dout, 8'h00);
        access("R1 slice0 after reset", 1, 1'b0, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule